// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a processor by watching its I2C traffic instead of a dedicated kick pin. The two bus lines arrive unsynchronized, pass through a synchronizer, and feed a condition detector that recognises START and STOP. A START, followed by at least one low-then-high cycle of SCL and then a STOP, counts as a complete bus sequence and restarts the timeout counter. If no complete sequence arrives within the selected period, the block raises its reset request for a fixed number of ticks. It then starts counting again from zero.

A two-bit period selector picks one of three timeout lengths or switches the watchdog off. The processor can rewrite the selector through a simple write strobe. Holding the write-protect input high freezes the selector. The counter advances only on cycles where the external timebase tick is high. While the supply reset input is active, the whole block is held cleared.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst_n` is low, `wdt_rst_o` is low, `period_sel_o` reads 2'b00 and the counter is held at zero. The first timeout after release comes exactly TICKS_LONG ticks later.
- R2: A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high. Both are judged on the outputs of a SYNC_STAGES-deep synchronizer.
- R3: A START, then SCL low, then SCL high, then a STOP restarts the counter. The STOP is seen by the counter three clock edges after SDA rises at the pins (two synchronizer stages plus one register), and the next timeout comes the selected period of ticks after that. Sequences repeated within the period keep `wdt_rst_o` low.
- R4: A STOP with no START before it is ignored. So is a START followed directly by a STOP with no SCL low phase between them.
- R5: Selector code 2'b00 selects TICKS_LONG, 2'b01 selects TICKS_MID and 2'b10 selects TICKS_SHORT.
- R6: Selector code 2'b11 disables the watchdog: `wdt_rst_o` stays low and the counter is held at zero.
- R7: When the counter has seen the selected number of ticks since its last restart, `wdt_rst_o` goes high at that tick's clock edge.
- R8: `wdt_rst_o` stays high for PULSE_TICKS ticks. It then falls, and the next timeout comes the selected period of ticks later.
- R9: A write with `cfg_we_i` high loads `cfg_wdata_i` into the selector on the next edge when `wp_i` is low. The write is ignored when `wp_i` is high. `period_sel_o` shows the selector.
- R10: The counter advances only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Supply reset, active low, asynchronous |
| tick_i | input | 1 | Timebase tick enable |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| cfg_we_i | input | 1 | Selector write strobe |
| cfg_wdata_i | input | 2 | Selector write data |
| wp_i | input | 1 | Write protect for the selector |
| period_sel_o | output | 2 | Current selector value |
| wdt_rst_o | output | 1 | Watchdog reset request, active high |

## Verification
A wrong counter or selector state shows up as a timeout edge that lands on the wrong cycle. The rise of `wdt_rst_o` is measured to the exact edge against the period, so a one-tick error is seen at the end of that period. A detector that accepts an incomplete sequence pushes the timeout out by the kick latency, and a detector that misses a complete one pulls it in. Either shift is visible within one period. A broken write-protect path shows at `period_sel_o` on the very next edge.

// File: rtl/bw_pkg.sv
package bw_pkg;

   // Period selector codes
   typedef enum logic [1:0] {
      SEL_LONG  = 2'b00,
      SEL_MID   = 2'b01,
      SEL_SHORT = 2'b10,
      SEL_OFF   = 2'b11
   } wd_sel_e;

   // Bus sequence tracking
   typedef enum logic [1:0] {
      BUS_IDLE    = 2'b00,
      BUS_STARTED = 2'b01,
      BUS_CLOCKED = 2'b10
   } bus_st_e;

   typedef enum logic {
      PH_COUNT = 1'b0,
      PH_PULSE = 1'b1
   } wd_phase_e;

endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("bw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bw_cond_det.sv
module bw_cond_det
   import bw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic kick_o
);

   logic    scl_q, sda_q;
   logic    start_c, stop_c;
   bus_st_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   assign start_c = scl_q & scl_s_i & sda_q & ~sda_s_i;
   assign stop_c  = scl_q & scl_s_i & ~sda_q & sda_s_i;

   always_comb begin
      state_d = state_q;
      if (start_c) state_d = BUS_STARTED;
      else if (stop_c) state_d = BUS_IDLE;
      else if (state_q == BUS_STARTED && !scl_s_i) state_d = BUS_CLOCKED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= BUS_IDLE;
      else        state_q <= state_d;
   end

   assign kick_o = stop_c && (state_q == BUS_CLOCKED);

   // R4
   no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BUS_IDLE) |=> (state_q != BUS_CLOCKED));

endmodule

// File: rtl/bw_timer.sv
module bw_timer
   import bw_pkg::*;
#(
   parameter int TICKS_LONG  = 1024,
   parameter int TICKS_MID   = 256,
   parameter int TICKS_SHORT = 64,
   parameter int PULSE_TICKS = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick_i,
   input  logic    kick_i,
   input  wd_sel_e sel_i,
   output logic    wdt_o
);

   localparam int MAX_T = (TICKS_LONG > PULSE_TICKS) ? TICKS_LONG : PULSE_TICKS;
   localparam int CNT_W = $clog2(MAX_T + 1);
   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(TICKS_LONG - 1);
   localparam logic [CNT_W-1:0] LIM_MID   = CNT_W'(TICKS_MID - 1);
   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(TICKS_SHORT - 1);
   localparam logic [CNT_W-1:0] LIM_PULSE = CNT_W'(PULSE_TICKS - 1);

   logic [CNT_W-1:0] cnt_q, lim_c;
   wd_phase_e        phase_q;

   always_comb begin
      case (sel_i)
         SEL_MID:   lim_c = LIM_MID;
         SEL_SHORT: lim_c = LIM_SHORT;
         default:   lim_c = LIM_LONG;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_COUNT;
         cnt_q   <= '0;
      end else if (sel_i == SEL_OFF) begin
         phase_q <= PH_COUNT;
         cnt_q   <= '0;
      end else if (phase_q == PH_COUNT) begin
         if (kick_i) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (cnt_q >= lim_c) begin
               phase_q <= PH_PULSE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else if (tick_i) begin
         if (cnt_q == LIM_PULSE) begin
            phase_q <= PH_COUNT;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign wdt_o = (phase_q == PH_PULSE);

   // R6
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_OFF) |=> !wdt_o);

   // R10
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_o) |-> $past(tick_i));

   // R8
   fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_o) |-> ($past(tick_i) || $past(sel_i) == SEL_OFF));

   // R3
   kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_i && !wdt_o && sel_i != SEL_OFF) |=> (cnt_q == '0 && !wdt_o));

   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_T - 1));

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
   import bw_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TICKS_LONG  = 1024,
   parameter int TICKS_MID   = 256,
   parameter int TICKS_SHORT = 64,
   parameter int PULSE_TICKS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       cfg_we_i,
   input  logic [1:0] cfg_wdata_i,
   input  logic       wp_i,
   output logic [1:0] period_sel_o,
   output logic       wdt_rst_o
);

   generate
      if (!(TICKS_LONG > TICKS_MID && TICKS_MID > TICKS_SHORT && TICKS_SHORT > 1)) begin : g_bad_periods
         $error("bus_watchdog: periods must satisfy LONG > MID > SHORT > 1");
      end
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("bus_watchdog: PULSE_TICKS must be at least 1");
      end
   endgenerate

   logic    scl_s, sda_s, kick;
   wd_sel_e sel_q;

   bw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   bw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   bw_cond_det u_det (
      .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s), .kick_o(kick));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sel_q <= SEL_LONG;
      else if (cfg_we_i && !wp_i)  sel_q <= wd_sel_e'(cfg_wdata_i);
   end

   assign period_sel_o = sel_q;

   bw_timer #(
      .TICKS_LONG(TICKS_LONG), .TICKS_MID(TICKS_MID),
      .TICKS_SHORT(TICKS_SHORT), .PULSE_TICKS(PULSE_TICKS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick),
      .sel_i(sel_q), .wdt_o(wdt_rst_o));

   // R9
   wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_i |=> $stable(sel_q));

endmodule

// File: tb/tb_bus_watchdog.sv
`timescale 1ns/1ps
module tb_bus_watchdog;

   localparam int PL = 48, PM = 32, PS = 24, PW = 3, H = 3;

   logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b1;
   logic scl_i = 1'b1, sda_i = 1'b1, cfg_we_i = 1'b0, wp_i = 1'b0;
   logic [1:0] cfg_wdata_i = 2'b00;
   logic [1:0] period_sel_o;
   logic wdt_rst_o;

   int checks = 0, errors = 0, tdiv = 1, tph = 0;
   bit done = 1'b0, seen_high = 1'b0;

   always #2.5 clk = ~clk;

   bus_watchdog #(.SYNC_STAGES(2), .TICKS_LONG(PL), .TICKS_MID(PM),
                  .TICKS_SHORT(PS), .PULSE_TICKS(PW)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .scl_i(scl_i), .sda_i(sda_i),
      .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .wp_i(wp_i),
      .period_sel_o(period_sel_o), .wdt_rst_o(wdt_rst_o));

   always @(negedge clk) begin
      tick_i = (tph == 0);
      tph = (tph + 1 >= tdiv) ? 0 : tph + 1;
      if (wdt_rst_o) seen_high = 1'b1;
   end

   function automatic int period_of(input logic [1:0] s);
      case (s)
         2'b01:   return PM;
         2'b10:   return PS;
         default: return PL;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; scl_i = 1'b1; sda_i = 1'b1; wp_i = 1'b0; cfg_we_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_sel(input logic [1:0] v);
      cfg_we_i = 1'b1; cfg_wdata_i = v;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   // Counts posedges from the current negedge until wdt_rst_o is seen high
   task automatic wait_rise(input int limit, output int n);
      n = -1;
      for (int i = 1; i <= limit; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (wdt_rst_o) begin n = i; return; end
      end
   endtask

   task automatic hold();
      repeat (H) @(negedge clk);
   endtask

   // START, SCL low, SCL high, STOP; returns at the negedge where SDA rises
   task automatic bus_txn();
      sda_i = 1'b0; hold();
      scl_i = 1'b0; hold();
      scl_i = 1'b1; hold();
      sda_i = 1'b1;
   endtask

   initial begin
      int n, w;
      // R1 reset state and hold
      rst_n = 1'b0;
      seen_high = 1'b0;
      repeat (3 * PL) @(negedge clk);
      check(wdt_rst_o == 1'b0 && !seen_high, "R1 output low in reset", wdt_rst_o, 0);
      check(period_sel_o == 2'b00, "R1 selector reset", period_sel_o, 0);
      rst_n = 1'b1;
      wait_rise(4 * PL, n);
      check(n == PL, "R1 R7 first timeout after release", n, PL);

      // R8 pulse width, then next timeout
      w = 0;
      while (wdt_rst_o) begin w++; @(negedge clk); end
      check(w == PW, "R8 pulse width", w, PW);
      wait_rise(4 * PL, n);
      check(n == PL, "R8 period after pulse", n, PL);

      // R5 R3 sweep of selector codes with a restart
      for (int s = 0; s < 3; s++) begin
         do_reset();
         write_sel(2'(s));
         check(period_sel_o == 2'(s), "R9 selector write", period_sel_o, s);
         bus_txn();
         wait_rise(4 * PL, n);
         check(n == period_of(2'(s)) + 3, "R5 R3 R2 timeout after restart", n, period_of(2'(s)) + 3);
      end

      // R6 disabled
      do_reset();
      write_sel(2'b11);
      seen_high = 1'b0;
      repeat (3 * PL) @(negedge clk);
      check(!seen_high, "R6 disabled never fires", seen_high, 0);

      // R9 write protect
      do_reset();
      wp_i = 1'b1;
      write_sel(2'b01);
      wp_i = 1'b0;
      check(period_sel_o == 2'b00, "R9 protected write ignored", period_sel_o, 0);
      bus_txn();
      wait_rise(4 * PL, n);
      check(n == PL + 3, "R9 period unchanged under protect", n, PL + 3);

      // R4 STOP with no START
      do_reset();
      scl_i = 1'b0; hold();
      sda_i = 1'b0; hold();
      scl_i = 1'b1; hold();
      sda_i = 1'b1;
      wait_rise(4 * PL, n);
      check(n == PL - 3 * H, "R4 lone stop ignored", n, PL - 3 * H);

      // R4 START then STOP without a clock phase
      do_reset();
      sda_i = 1'b0; hold();
      sda_i = 1'b1;
      wait_rise(4 * PL, n);
      check(n == PL - H, "R4 unclocked sequence ignored", n, PL - H);

      // R3 repeated restarts keep the output low
      do_reset();
      write_sel(2'b10);
      seen_high = 1'b0;
      for (int k = 0; k < 8; k++) begin
         bus_txn(); hold();
      end
      check(!seen_high, "R3 repeated restarts", seen_high, 0);

      // R10 tick every second cycle
      tdiv = 2;
      do_reset();
      wait_rise(8 * PL, n);
      check(n >= 2 * PL - 1 && n <= 2 * PL, "R10 counts only ticks", n, 2 * PL);
      tdiv = 1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule